// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings for a 32-bit virtual address space and a 30-bit physical address space with 4 KiB pages. Sixteen entries are searched in parallel on every lookup. The physical address, a hit flag and a miss flag come back combinationally in the same cycle, so a requester can start miss handling on the very next edge. The buffer only reports a miss. Fetching the mapping from memory is the job of whatever sits around it.

Entries are loaded through a write port. It takes a virtual page number, a physical page number and an initial dirty flag, and places them either at an explicit slot or at the slot named by a free-running 4-bit linear feedback shift register. That register is visible on an output, so software can tell where a pseudorandom refill will land. On every hit the hardware sets the entry's reference flag. On a hit for a store it also sets the entry's dirty flag. A single-cycle invalidate-all input drops every mapping at once.

Top module: `tlb_fa`

## Requirements
- R1: Virtual address bits 31..12 form the page number to translate. Bits 11..0 pass straight through. On a hit, lk_paddr equals {stored physical page number (18 bits), lk_vaddr[11:0]}.
- R2: lk_hit and lk_miss are combinational in the cycle the lookup is presented. When lk_valid is 1, exactly one of them is 1. When lk_valid is 0, both are 0. On a miss, lk_paddr, lk_dirty and lk_ref are all 0.
- R3: All 16 entries are compared at once, and only entries whose valid flag is set can match. If more than one valid entry matches, the entry with the lowest index supplies the result.
- R4: With wr_en=1 and wr_rand=0, the entry at wr_idx is replaced on the clock edge. Its valid flag becomes 1, it takes wr_vpn, wr_ppn and wr_dirty, and its reference flag becomes 0.
- R5: With wr_en=1 and wr_rand=1, the entry replaced is the one whose index equals rand_idx in the write cycle, and wr_idx is ignored.
- R6: rand_idx is 1 after reset. On every clock edge it advances as next = {q[2:0], q[3]^q[2]}. It is never 0 and repeats with period 15.
- R7: A hit sets the matched entry's reference flag on the clock edge. lk_ref reports the value the flag had before the current access.
- R8: A hit with lk_write=1 sets the matched entry's dirty flag on the clock edge. A hit with lk_write=0 leaves the dirty flag unchanged. lk_dirty reports the value before the current access.
- R9: When flush_all is 1, every valid flag is cleared on that edge. A write presented in the same cycle is dropped, so every lookup in the next cycle misses.
- R10: Reset is synchronous and active high. It clears every entry, so all lookups miss after reset.
- R11: If a write and a hit target the same slot in the same cycle, the lookup reports the old contents and the written contents win: the reference flag is 0 and the dirty flag is wr_dirty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request present |
| lk_write | input | 1 | Lookup is for a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent |
| lk_paddr | output | 30 | Translated physical address |
| lk_dirty | output | 1 | Dirty flag of matched entry before this access |
| lk_ref | output | 1 | Reference flag of matched entry before this access |
| wr_en | input | 1 | Load an entry |
| wr_rand | input | 1 | Use the pseudorandom slot instead of wr_idx |
| wr_idx | input | 4 | Explicit slot to load |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_ppn | input | 18 | Physical page number to store |
| wr_dirty | input | 1 | Initial dirty flag |
| rand_idx | output | 4 | Current pseudorandom slot |

## Verification
A corrupted tag or valid flag shows up on the first lookup of the affected page, in that same cycle. It appears either as a miss where a hit is due, or as a hit that carries the wrong physical page. A wrong priority choice shows only when two entries share a page number, so the bench creates that case on purpose. Errors in the reference or dirty flags stay hidden until the next lookup of the same page, one cycle later at the earliest. The bench therefore repeats lookups back to back, and it keeps a full model of every entry to predict the result of each lookup. The pseudorandom slot is compared with an independent register model on every cycle of a long run. A wrong feedback would also move the target of a random refill, and the follow-up lookups across all sixteen pages expose that.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 30;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int N_ENT = 16;
    localparam int IDX_W = $clog2(N_ENT);

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             dirty;
        logic             refd;
    } tlb_entry_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } tlb_match_t;

    // Feedback from the two top bits; maximal length for a 4-bit register.
    function automatic logic [IDX_W-1:0] lfsr_step(input logic [IDX_W-1:0] q);
        return {q[IDX_W-2:0], q[IDX_W-1] ^ q[IDX_W-2]};
    endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= IDX_W'(1);
        else     q <= lfsr_step(q);
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_entry_t [N_ENT-1:0] ents,
    input  logic [VPN_W-1:0]       vpn,
    output tlb_match_t             res
);
    logic [N_ENT-1:0] hits;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hits[g] = ents[g].valid && (ents[g].vpn == vpn);
    end

    // Scan from the top so the lowest matching index is the last to win.
    always_comb begin
        res = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                res.hit = 1'b1;
                res.idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_slot,
    input  tlb_entry_t             wr_entry,
    input  logic                   upd_en,
    input  logic [IDX_W-1:0]       upd_idx,
    input  logic                   upd_dirty,
    output tlb_entry_t [N_ENT-1:0] ents
);
    tlb_entry_t ent_q [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (flush) begin
                ent_q[g].valid <= 1'b0;
            end else if (wr_en && wr_slot == IDX_W'(g)) begin
                ent_q[g] <= wr_entry;
            end else if (upd_en && upd_idx == IDX_W'(g)) begin
                ent_q[g].refd <= 1'b1;
                if (upd_dirty) ent_q[g].dirty <= 1'b1;
            end
        end
        assign ents[g] = ent_q[g];
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_all,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_dirty,
    output logic             lk_ref,
    input  logic             wr_en,
    input  logic             wr_rand,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_dirty,
    output logic [IDX_W-1:0] rand_idx
);
    tlb_entry_t [N_ENT-1:0] ents;
    tlb_match_t             mres;
    tlb_entry_t             sel;
    tlb_entry_t             new_ent;
    logic [IDX_W-1:0]       slot;

    tlb_lfsr u_lfsr (.clk(clk), .rst(rst), .q(rand_idx));

    tlb_match u_match (
        .ents (ents),
        .vpn  (lk_vaddr[VA_W-1:OFF_W]),
        .res  (mres)
    );

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.vpn   = wr_vpn;
        new_ent.ppn   = wr_ppn;
        new_ent.dirty = wr_dirty;
        slot          = wr_rand ? rand_idx : wr_idx;
    end

    tlb_store u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_all),
        .wr_en     (wr_en),
        .wr_slot   (slot),
        .wr_entry  (new_ent),
        .upd_en    (lk_hit),
        .upd_idx   (mres.idx),
        .upd_dirty (lk_write),
        .ents      (ents)
    );

    always_comb begin
        sel      = ents[mres.idx];
        lk_hit   = lk_valid && mres.hit;
        lk_miss  = lk_valid && !mres.hit;
        lk_paddr = lk_hit ? {sel.ppn, lk_vaddr[OFF_W-1:0]} : '0;
        lk_dirty = lk_hit && sel.dirty;
        lk_ref   = lk_hit && sel.refd;
    end
endmodule

// File: rtl/tlb_fa_checker.sv
module tlb_fa_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             flush_all,
    input logic             lk_valid,
    input logic             lk_write,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             lk_dirty,
    input logic             lk_ref,
    input logic             wr_en,
    input logic             wr_rand,
    input logic [IDX_W-1:0] wr_idx,
    input logic [VPN_W-1:0] wr_vpn,
    input logic [PPN_W-1:0] wr_ppn,
    input logic             wr_dirty,
    input logic [IDX_W-1:0] rand_idx
);
    logic            s1, s2;
    logic            p_rhit, p_whit;
    logic [VA_W-1:0] p_va;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0; s2 <= 1'b0;
            p_rhit <= 1'b0; p_whit <= 1'b0; p_va <= '0;
        end else begin
            s1 <= 1'b1; s2 <= s1;
            p_rhit <= lk_hit && !wr_en && !flush_all;
            p_whit <= lk_hit && lk_write && !wr_en && !flush_all;
            p_va   <= lk_vaddr;
        end
    end

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);
    assert_hit_miss_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_miss));
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));
    assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        rand_idx != '0);
    assert_lfsr_moves_R6: assert property (@(posedge clk) disable iff (rst)
        s2 |-> rand_idx != $past(rand_idx));
    assert_ref_after_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (p_rhit && lk_valid && lk_vaddr == p_va) |-> (lk_hit && lk_ref));
    assert_dirty_after_store_R8: assert property (@(posedge clk) disable iff (rst)
        (p_whit && lk_valid && lk_vaddr == p_va) |-> (lk_hit && lk_dirty));
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> !lk_hit);
    assert_reset_empty_R10: assert property (@(posedge clk) disable iff (rst)
        !s1 |-> !lk_hit);
endmodule

bind tlb_fa tlb_fa_checker u_chk (.*);

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, flush_all, lk_valid, lk_write, wr_en, wr_rand, wr_dirty;
    logic [31:0] lk_vaddr;
    logic [3:0]  wr_idx, rand_idx;
    logic [19:0] wr_vpn;
    logic [17:0] wr_ppn;
    logic        lk_hit, lk_miss, lk_dirty, lk_ref;
    logic [29:0] lk_paddr;

    tlb_fa u_tlb_fa (
        .clk(clk), .rst(rst), .flush_all(flush_all),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .lk_dirty(lk_dirty), .lk_ref(lk_ref),
        .wr_en(wr_en), .wr_rand(wr_rand), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_dirty(wr_dirty),
        .rand_idx(rand_idx)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench-side model of the entries and the slot register.
    bit        m_v [16];
    bit [19:0] m_vpn [16];
    bit [17:0] m_ppn [16];
    bit        m_d [16];
    bit        m_r [16];
    bit [3:0]  m_lfsr;

    always @(posedge clk) begin
        if (rst) m_lfsr <= 4'd1;
        else     m_lfsr <= {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
    end

    typedef struct {
        bit        hit;
        bit [29:0] pa;
        bit        d;
        bit        r;
        string     tag;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush_all = 0; lk_valid = 0; lk_write = 0; lk_vaddr = '0;
        wr_en = 0; wr_rand = 0; wr_idx = '0; wr_vpn = '0; wr_ppn = '0; wr_dirty = 0;
    endtask

    function automatic exp_t predict(input bit [31:0] va, input string tag);
        exp_t e;
        int   found = -1;
        e.hit = 0; e.pa = '0; e.d = 0; e.r = 0; e.tag = tag;
        for (int i = 0; i < 16; i++) begin
            if (found < 0 && m_v[i] && m_vpn[i] == va[31:12]) found = i;
        end
        if (found >= 0) begin
            e.hit = 1; e.pa = {m_ppn[found], va[11:0]}; e.d = m_d[found]; e.r = m_r[found];
        end
        return e;
    endfunction

    function automatic int find(input bit [31:0] va);
        for (int i = 0; i < 16; i++) if (m_v[i] && m_vpn[i] == va[31:12]) return i;
        return -1;
    endfunction

    // Lookup, optionally with a write in the same cycle (write wins its slot).
    task automatic lookup_wr(input bit [31:0] va, input bit st, input bit do_wr,
                             input bit rnd, input int idx, input bit [19:0] vpn,
                             input bit [17:0] ppn, input bit d, input string tag);
        int s;
        int f;
        @(negedge clk);
        idle_inputs();
        lk_valid = 1; lk_write = st; lk_vaddr = va;
        if (do_wr) begin
            wr_en = 1; wr_rand = rnd; wr_idx = 4'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_dirty = d;
        end
        sb.push_back(predict(va, tag));
        f = find(va);
        if (f >= 0) begin
            m_r[f] = 1;
            if (st) m_d[f] = 1;
        end
        if (do_wr) begin
            s = rnd ? int'(m_lfsr) : idx;
            m_v[s] = 1; m_vpn[s] = vpn; m_ppn[s] = ppn; m_d[s] = d; m_r[s] = 0;
        end
    endtask

    task automatic lookup(input bit [31:0] va, input bit st, input string tag);
        lookup_wr(va, st, 0, 0, 0, '0, '0, 0, tag);
    endtask

    task automatic write(input bit rnd, input int idx, input bit [19:0] vpn,
                         input bit [17:0] ppn, input bit d);
        int s;
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_rand = rnd; wr_idx = 4'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_dirty = d;
        s = rnd ? int'(m_lfsr) : idx;
        m_v[s] = 1; m_vpn[s] = vpn; m_ppn[s] = ppn; m_d[s] = d; m_r[s] = 0;
    endtask

    // Monitor: compare just before the edge that ends each lookup cycle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/2 - 1);
            if (lk_valid && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(lk_hit == e.hit && lk_miss == !e.hit, {e.tag, " hit"}, int'(lk_hit), int'(e.hit));
                check(lk_paddr == e.pa, {e.tag, " paddr"}, int'(lk_paddr), int'(e.pa));
                check(lk_dirty == e.d && lk_ref == e.r, {e.tag, " flags"},
                      int'({lk_dirty, lk_ref}), int'({e.d, e.r}));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_d[i] = 0; m_r[i] = 0;
        end
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R10 and R6: empty after reset, slot register starts at 1.
        #1;
        check(rand_idx == 4'd1, "R6 reset value", int'(rand_idx), 1);
        lookup(32'h0000_0000, 0, "R10 empty");
        lookup(32'hFFFF_F123, 0, "R10 empty");

        // R2: no lookup, no flags.
        @(negedge clk); idle_inputs(); #2;
        check(!lk_hit && !lk_miss, "R2 idle", int'({lk_hit, lk_miss}), 0);

        // R4 and R1: explicit load then translate, offset passes through.
        write(0, 5, 20'h12345, 18'h2ABCD, 0);
        lookup(32'h1234_5ABC, 0, "R1 R4 first hit");
        @(negedge clk); idle_inputs(); #2;
        check(lk_paddr == 30'h0, "R2 paddr quiet", int'(lk_paddr), 0);
        // R7: reference flag seen on the next lookup.
        lookup(32'h1234_5001, 0, "R7 ref set");
        // R8: store hit sets dirty, read hit leaves it.
        lookup(32'h1234_5FFF, 1, "R8 store hit");
        lookup(32'h1234_5000, 0, "R8 dirty set");
        lookup(32'h1234_5000, 0, "R8 dirty kept");
        // R2: miss on an absent page.
        lookup(32'h7777_7000, 0, "R2 miss");

        // R3: duplicate page, lowest index wins (intentional multi-match).
        write(0, 9, 20'h00777, 18'h00111, 0);
        write(0, 3, 20'h00777, 18'h00222, 0);
        lookup(32'h0077_7444, 0, "R3 lowest index");
        // R4: explicit overwrite of slot 3 leaves slot 9 visible.
        write(0, 3, 20'h0ABCD, 18'h3FFFF, 1);
        lookup(32'h0077_7444, 0, "R3 R4 remaining copy");
        lookup(32'h0ABC_D010, 0, "R4 loaded dirty");

        // R5: fill every slot, then a random refill evicts the predicted one.
        for (int i = 0; i < 16; i++) write(0, i, 20'h40000 + 20'(i), 18'h00100 + 18'(i), 0);
        write(1, 7, 20'h5AAAA, 18'h15555, 0);
        for (int i = 0; i < 16; i++)
            lookup({20'h40000 + 20'(i), 12'h321}, 0, "R5 after random refill");
        lookup(32'h5AAA_A321, 0, "R5 new page");
        for (int k = 0; k < 3; k++) begin
            write(1, 0, 20'h60000 + 20'(k), 18'h20000 + 18'(k), 1);
            lookup({20'h60000 + 20'(k), 12'h0}, 0, "R5 random refill");
        end

        // R11: write and hit on the same slot in one cycle.
        write(0, 2, 20'h0C0DE, 18'h0BEEF, 0);
        lookup(32'h0C0D_E000, 0, "R11 prime");
        lookup_wr(32'h0C0D_E004, 1, 1, 0, 2, 20'h0D00D, 18'h01234, 1, "R11 old contents");
        lookup(32'h0D00_D008, 0, "R11 new contents");
        lookup(32'h0C0D_E004, 0, "R11 old gone");

        // R6: slot register against the model over many cycles.
        for (int n = 0; n < 20; n++) begin
            @(negedge clk); idle_inputs(); #1;
            check(rand_idx == m_lfsr && rand_idx != 0, "R6 sequence", int'(rand_idx), int'(m_lfsr));
        end

        // R9: flush with a concurrent write; the write is dropped.
        @(negedge clk);
        idle_inputs();
        flush_all = 1; wr_en = 1; wr_idx = 4'd4; wr_vpn = 20'h0F00F; wr_ppn = 18'h0F00F;
        for (int i = 0; i < 16; i++) m_v[i] = 0;
        lookup(32'h0F00_F000, 0, "R9 dropped write");
        lookup(32'h0D00_D000, 0, "R9 flushed");
        lookup(32'h4000_0000, 0, "R9 flushed");
        write(0, 0, 20'h0F00F, 18'h0F00F, 0);
        lookup(32'h0F00_F0F0, 0, "R4 reload after flush");

        @(negedge clk); idle_inputs();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2 all lookups observed", sb.size(), 0);
        finish_run();
    end
endmodule